// File: doc/BRIEF.md
# Four-Motor H-Bridge PWM Driver

This block produces the gate-level drive for four DC motors, each sitting in its own full H-bridge with two terminals (A and B). Every terminal has a high-side and a low-side switch, so each motor takes four drive lines. A shared 12-bit duty value sets how long the driving high-side switch conducts within each PWM period. A per-motor 2-bit motion code selects which terminal is driven and how the motor is held when it is not being driven.

The PWM time base is a 12-bit counter that advances once per prescaler tick. The prescaler divides the system clock by (div + 2), so one PWM period lasts 4096 × (div + 2) clocks. A new duty value is picked up only when the counter wraps, which keeps every period's pulse whole. A global halt input pulls every motor into the coast-with-one-terminal-grounded state in the same cycle and drops the shared bridge enable.

Top module: `hbridge_pwm4`

## Requirements
- R1: The motion word holds one 2-bit code per motor; motor m uses bits [2m+1:2m]. Drive lines are indexed so that bit 2m of `mot_hi`/`mot_lo` is terminal A of motor m and bit 2m+1 is terminal B.
- R2: Code 2'b10 (forward): terminal A high side follows the PWM phase, terminal B low side is on, the other two lines are off.
- R3: Code 2'b01 (reverse): terminal B high side follows the PWM phase, terminal A low side is on, the other two lines are off.
- R4: Code 2'b00 (stop): only the terminal B low side is on; all other lines of that motor are off.
- R5: Code 2'b11 (short brake): both low sides are on and both high sides are off.
- R6: While `halt` is high, in that same cycle every motor shows the stop pattern of R4 and `mot_en` is low, whatever the codes and duty are.
- R7: While `rst_n` is low all drive lines and `mot_en` are 0; after reset the PWM phase stays off until the first counter wrap, even if a nonzero duty is applied.
- R8: One PWM period lasts 4096 × (div + 2) clocks, and the PWM phase is on for (div + 2) × duty clocks of it.
- R9: A duty of 0 keeps the PWM phase off for the whole period; a duty of 4095 keeps it on for the whole period.
- R10: A duty change takes effect only at the next counter wrap; the period in progress keeps its old pulse width.
- R11: The high side and low side of the same terminal are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div | input | 16 | Prescaler setting; clock divided by div + 2 |
| duty | input | 12 | Shared PWM duty, 0 to 4095 |
| motion | input | 8 | Four 2-bit motion codes, motor 0 in the low bits |
| halt | input | 1 | Global stop override |
| mot_hi | output | 8 | High-side drives, bit 2m = terminal A, 2m+1 = terminal B of motor m |
| mot_lo | output | 8 | Low-side drives, same indexing as mot_hi |
| mot_en | output | 1 | Shared bridge enable |

## Verification
A wrong prescaler or counter state shows up as a wrong on-time count over a full period window, visible only after a whole period of 8192 or more clocks. A duty register that loads at the wrong time shows as the period already in progress changing its pulse width, so the bench aligns on a rising edge of the drive line and counts the two periods that straddle the change. Decode faults and halt faults are combinational from the inputs and show on the drive lines in the very cycle the code or halt changes.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  typedef enum logic [1:0] {
    MOT_STOP  = 2'b00,
    MOT_REV   = 2'b01,
    MOT_FWD   = 2'b10,
    MOT_BRAKE = 2'b11
  } motion_e;

  // PWM phase for a counter value against a latched duty; full scale is always on
  function automatic logic pwm_level(logic [31:0] cnt, logic [31:0] dty, logic [31:0] full);
    return (dty == full) || (cnt < dty);
  endfunction

  // Terminal drive as {lo_b, lo_a, hi_b, hi_a}
  function automatic logic [3:0] leg_drive(motion_e m, logic pwm);
    case (m)
      MOT_FWD:   return {1'b1, 1'b0, 1'b0, pwm};
      MOT_REV:   return {1'b0, 1'b1, pwm, 1'b0};
      MOT_BRAKE: return 4'b1100;
      default:   return 4'b1000;
    endcase
  endfunction

  // Prescaler terminal count for a divide-by-(d+2)
  function automatic logic [31:0] pre_limit(logic [31:0] d);
    return d + 32'd1;
  endfunction

endpackage

// File: rtl/hbp_prescale.sv
module hbp_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] pre_cnt;
  logic [PW-1:0] limit;

  assign limit = PW'(hbp_pkg::pre_limit(32'(div)));
  assign tick  = (pre_cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else           pre_cnt <= pre_cnt + 1'b1;
  end

  // R8
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/hbp_pwm_core.sv
module hbp_pwm_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_q;

  assign wrap = tick && (cnt == CNT_MAX);
  assign pwm  = hbp_pkg::pwm_level(32'(cnt), 32'(duty_q), 32'(CNT_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      duty_q <= '0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      if (wrap) duty_q <= duty;
    end
  end

  // R10
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_q));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R9
  duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm);

endmodule

// File: rtl/hbp_leg.sv
module hbp_leg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       force_stop,
  input  logic [1:0] code,
  input  logic       pwm,
  output logic [1:0] hi,
  output logic [1:0] lo
);
  import hbp_pkg::*;

  logic [3:0] drv;

  always_comb begin
    if (!run)            drv = 4'b0000;
    else if (force_stop) drv = leg_drive(MOT_STOP, 1'b0);
    else                 drv = leg_drive(motion_e'(code), pwm);
  end

  assign hi = drv[1:0];
  assign lo = drv[3:2];

  // R11
  leg_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi & lo) == 2'b00));

endmodule

// File: rtl/hbridge_pwm4.sv
module hbridge_pwm4 #(
  parameter int N_MOTORS = 4,
  parameter int CNT_W    = 12,
  parameter int DIV_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      div,
  input  logic [CNT_W-1:0]      duty,
  input  logic [2*N_MOTORS-1:0] motion,
  input  logic                  halt,
  output logic [2*N_MOTORS-1:0] mot_hi,
  output logic [2*N_MOTORS-1:0] mot_lo,
  output logic                  mot_en
);
  localparam int LINES = 2 * N_MOTORS;

  logic tick;
  logic pwm;
  logic wrap;
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign mot_en = run_q & ~halt;

  hbp_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
  );

  hbp_pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .duty(duty), .pwm(pwm), .wrap(wrap)
  );

  for (genvar g = 0; g < N_MOTORS; g++) begin : g_leg
    hbp_leg u_leg (
      .clk(clk), .rst_n(rst_n), .run(run_q), .force_stop(halt),
      .code(motion[2*g +: 2]), .pwm(pwm),
      .hi(mot_hi[2*g +: 2]), .lo(mot_lo[2*g +: 2])
    );
  end

  // R6
  halt_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!mot_en && (mot_hi == '0)));

  // R11
  bridge_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mot_hi & mot_lo) == LINES'(0)));

  // R10
  wrap_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> tick);

endmodule

// File: tb/sim_hbridge_pwm4.sv
module sim_hbridge_pwm4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div = '0;
  logic [11:0] duty = '0;
  logic [7:0]  motion = '0;
  logic        halt = 1'b0;
  logic [7:0]  mot_hi, mot_lo;
  logic        mot_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hbridge_pwm4 u0 (
    .clk(clk), .rst_n(rst_n), .div(div), .duty(duty), .motion(motion),
    .halt(halt), .mot_hi(mot_hi), .mot_lo(mot_lo), .mot_en(mot_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected {lo_b, lo_a, hi_b, hi_a} for one motor, from the requirements
  function automatic logic [3:0] want(logic [1:0] c, logic ph);
    logic [3:0] r;
    r = 4'b0;
    if (c == 2'b10)      begin r[0] = ph; r[3] = 1'b1; end
    else if (c == 2'b01) begin r[1] = ph; r[2] = 1'b1; end
    else if (c == 2'b11) begin r[2] = 1'b1; r[3] = 1'b1; end
    else                 r[3] = 1'b1;
    return r;
  endfunction

  task automatic check_drive(input string req, input logic [7:0] word, input logic ph);
    logic [7:0] eh, el;
    eh = '0; el = '0;
    for (int m = 0; m < 4; m++) begin
      logic [3:0] w;
      w = want(word[2*m +: 2], ph);
      eh[2*m] = w[0]; eh[2*m+1] = w[1];
      el[2*m] = w[2]; el[2*m+1] = w[3];
    end
    check({req, " hi"}, 32'(mot_hi), 32'(eh));
    check({req, " lo"}, 32'(mot_lo), 32'(el));
  endtask

  task automatic count_on(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mot_hi[0]) hits++;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    // R7 outputs quiet in reset
    check("R7 hi in reset", 32'(mot_hi), 0);
    check("R7 lo in reset", 32'(mot_lo), 0);
    check("R7 en in reset", 32'(mot_en), 0);
    motion = 8'b0000_0010;
    duty = 12'd4095;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R7 PWM phase off before the first wrap
    check("R7 pwm before wrap", 32'(mot_hi[0]), 0);
    check("R7 en after reset", 32'(mot_en), 1);
  endtask

  task automatic t_window(input string req, input logic [11:0] d, input logic [15:0] dv,
                          input int exp_on);
    int per, hits;
    duty = d; div = dv;
    per = 4096 * (int'(dv) + 2);
    repeat (2 * per) @(negedge clk);
    count_on(per, hits);
    check(req, 32'(hits), 32'(exp_on));
  endtask

  task automatic t_decode(input logic ph);
    // R1 R2 R3 R4 R5 motor0 fwd, motor1 rev, motor2 stop, motor3 brake
    motion = 8'b11_00_01_10;
    @(negedge clk);
    check_drive(ph ? "R1 R2 R3 R4 R5 mix on" : "R2 R3 mix off", motion, ph);
    motion = 8'b01_10_11_00;
    @(negedge clk);
    check_drive("R1 R2 R3 R4 R5 rotated", motion, ph);
    motion = 8'b0000_0010;
    @(negedge clk);
  endtask

  task automatic t_halt;
    motion = 8'b10_01_11_10;
    halt = 1'b1;
    #1;
    // R6 same-cycle override
    check_drive("R6 halt", 8'h00, 1'b0);
    check("R6 en low", 32'(mot_en), 0);
    @(negedge clk);
    check_drive("R6 halt held", 8'h00, 1'b0);
    halt = 1'b0;
    #1;
    check_drive("R6 released", motion, 1'b1);
    check("R6 en back", 32'(mot_en), 1);
    motion = 8'b0000_0010;
    @(negedge clk);
  endtask

  task automatic t_latch;
    logic prev;
    int hits1, hits2, guard;
    prev = 1'b1;
    guard = 0;
    while (guard < 20000) begin
      @(negedge clk);
      if (mot_hi[0] && !prev) break;
      prev = mot_hi[0];
      guard++;
    end
    // first sample is the rising one
    hits1 = 1;
    for (int i = 1; i < 8192; i++) begin
      if (i == 100) duty = 12'd3000;
      @(negedge clk);
      if (mot_hi[0]) hits1++;
    end
    // R10 period in progress keeps old width, next uses new width
    check("R10 old period", 32'(hits1), 2000);
    count_on(8192, hits2);
    check("R10 new period", 32'(hits2), 6000);
  endtask

  initial begin
    t_reset();
    t_window("R9 full scale on", 12'd4095, 16'd0, 8192);
    t_decode(1'b1);
    t_halt();
    t_window("R9 zero duty off", 12'd0, 16'd0, 0);
    t_decode(1'b0);
    t_window("R8 duty 1000", 12'd1000, 16'd0, 2000);
    t_latch();
    t_window("R8 divider 1", 12'd2048, 16'd1, 6144);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule